// File: doc/BRIEF.md
# Self-ID Sequence Stream Parser

The parser sits behind a serial-bus link layer. After every bus reset the link delivers self-ID quadlets, and the parser takes them one 32-bit word per valid/ready handshake. Each node describes itself with a sequence of one to four quadlets. The parser reassembles these sequences, checks their framing and decodes each complete one. For each decoded sequence it emits a single result beat. That beat holds the node's header fields, the number of quadlets used, and a flat vector with one 2-bit status slot per possible port.

A malformed sequence raises a one-cycle error flag and increments a sticky error counter, and the parser drops the sequence. The parser then skips extension quadlets until a quadlet that can open a sequence arrives. An end-of-batch marker on the input closes the batch, so the next batch always starts clean. Input ready falls only while a result waits on a stalled output.

Top module: `selfid_stream_parser`

## Requirements
- R1: After a synchronous active-high reset, res_valid and err_flag are 0, err_count is 0 and in_ready is 1.
- R2: A sequence's first quadlet must carry identifier 2 in bits 31:30. It supplies the result header: node ID from bits 29:24, link-on from bit 22, gap count from bits 21:16, speed code from bits 15:14, contender from bit 11, power class from bits 10:8 and initiated-reset from bit 1.
- R3: Bit 0 of a quadlet set means the next accepted quadlet continues the same sequence. Bit 0 clear closes the sequence. Exactly one result beat is produced per well-formed sequence, and res_nquad gives its length (1 to 4).
- R4: Every quadlet after the first must carry identifier 2, have bit 23 set, and carry the value k-1 in bits 22:20 when it is the k-th extension (k = 1, 2, 3). Any other value is a protocol error, and that sequence produces no result.
- R5: Bit 0 still set on the fourth quadlet of a sequence is a protocol error, and that sequence produces no result.
- R6: A quadlet arriving where a sequence must begin causes a protocol error if its identifier is not 2, or if its bit 23 is set, except during the skipping state of R9.
- R7: Port p occupies 2-bit slot p of res_ports (bits 2p+1:2p). Its value is taken from quadlet (p+5)/8 at bits s+1:s, where s = 16 - 2*((p+5) mod 8). Slots of ports whose quadlet lies beyond the sequence length read 0. Values are 0 absent, 1 not connected, 2 to parent, 3 to child.
- R8: in_last on a quadlet whose bit 0 is set is a protocol error, and no partial result is emitted. The quadlet after in_last is always decoded as the start of a new sequence.
- R9: After a protocol error on a quadlet without in_last, the parser discards quadlets with bit 23 set without counting errors. The first quadlet with bit 23 clear is handled as a sequence start.
- R10: Each protocol error raises err_flag for exactly the cycle after the offending quadlet is accepted. err_count rises by one per error.
- R11: in_ready is low exactly while res_valid is high and res_ready is low. During such a stall every result output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Quadlet offered |
| in_ready | output | 1 | Quadlet can be taken |
| in_data | input | 32 | Self-ID quadlet |
| in_last | input | 1 | Quadlet ends the current batch |
| res_valid | output | 1 | Result beat offered |
| res_ready | input | 1 | Result beat taken |
| res_phy_id | output | 6 | Node ID |
| res_link_on | output | 1 | Link-on flag |
| res_gap | output | 6 | Gap count |
| res_speed | output | 2 | Speed code |
| res_contender | output | 1 | Contender flag |
| res_power | output | 3 | Power class |
| res_init_reset | output | 1 | Initiated-reset flag |
| res_nquad | output | 3 | Quadlets in the sequence |
| res_ports | output | 54 | 27 port status slots, 2 bits each |
| err_flag | output | 1 | Protocol error pulse |
| err_count | output | 16 | Sticky protocol error count |

## Verification
The assertions assume that the sink never sees more than one sequence completion per cycle. They also assume that in_last, like in_data, matters only when a quadlet is actually accepted. The stimulus holds in_data and in_last steady while in_valid waits on in_ready, and it toggles res_ready at random so that stalls arise both mid-sequence and on completions. Corrupted sequences are drawn from a fixed set of framing faults: a wrong sequence number, a cleared or set bit 23, a foreign identifier, an overlong sequence, and a batch cut mid-sequence. Stray extension quadlets are mixed in between sequences to exercise the skipping path.

// File: rtl/sidp_pkg.sv
package sidp_pkg;

  localparam int QUAD_W = 32;
  localparam logic [1:0] ID_SELF = 2'd2;

  typedef enum logic [1:0] {
    FS_IDLE    = 2'd0,
    FS_COLLECT = 2'd1,
    FS_HUNT    = 2'd2
  } frame_state_e;

  typedef struct packed {
    logic [5:0] phy;
    logic       link_on;
    logic [5:0] gap;
    logic [1:0] speed;
    logic       contender;
    logic [2:0] power;
    logic       init_reset;
  } node_hdr_t;

  function automatic logic [1:0] quad_id(input logic [QUAD_W-1:0] q);
    return q[31:30];
  endfunction

  function automatic logic quad_ext(input logic [QUAD_W-1:0] q);
    return q[23];
  endfunction

  function automatic logic quad_more(input logic [QUAD_W-1:0] q);
    return q[0];
  endfunction

  function automatic logic [2:0] quad_seq(input logic [QUAD_W-1:0] q);
    return q[22:20];
  endfunction

  function automatic node_hdr_t hdr_of(input logic [QUAD_W-1:0] q);
    node_hdr_t h;
    h.phy        = q[29:24];
    h.link_on    = q[22];
    h.gap        = q[21:16];
    h.speed      = q[15:14];
    h.contender  = q[11];
    h.power      = q[10:8];
    h.init_reset = q[1];
    return h;
  endfunction

  // Quadlet that carries port p.
  function automatic int slot_word(input int p);
    return (p + 5) / 8;
  endfunction

  // Low bit position of port p inside its quadlet.
  function automatic int slot_shift(input int p);
    return 16 - 2 * ((p + 5) % 8);
  endfunction

  function automatic int port_capacity(input int nq);
    return 8 * nq - 5;
  endfunction

endpackage

// File: rtl/sidp_framer.sv
module sidp_framer
  import sidp_pkg::*;
#(
  parameter int MAX_Q = 4,
  localparam int QCW = $clog2(MAX_Q + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          fire,
  input  logic [QUAD_W-1:0]             q,
  input  logic                          last,
  output logic                          seq_done,
  output logic                          seq_err,
  output logic [QCW-1:0]                seq_nq,
  output logic [MAX_Q-1:0][QUAD_W-1:0]  seq_words
);

  frame_state_e                   state, nxt_state;
  logic [QCW-1:0]                 qn, nxt_qn;
  logic [MAX_Q-1:0][QUAD_W-1:0]   hold_q;
  logic                           wr_en;
  logic [QCW-1:0]                 wr_idx;
  logic                           id_ok;
  logic [2:0]                     want_seq;

  assign id_ok    = (quad_id(q) == ID_SELF);
  assign want_seq = 3'(qn - QCW'(1));
  assign wr_idx   = (state == FS_COLLECT) ? qn : '0;

  always_comb begin
    nxt_state = state;
    nxt_qn    = qn;
    seq_done  = 1'b0;
    seq_err   = 1'b0;
    seq_nq    = '0;
    wr_en     = 1'b0;
    if (fire) begin
      if (state == FS_COLLECT) begin
        if (!id_ok || !quad_ext(q) || quad_seq(q) != want_seq) begin
          seq_err = 1'b1;
        end else if (quad_more(q)) begin
          if (int'(qn) + 1 >= MAX_Q || last) seq_err = 1'b1;
          else begin
            wr_en  = 1'b1;
            nxt_qn = qn + QCW'(1);
          end
        end else begin
          seq_done = 1'b1;
          seq_nq   = qn + QCW'(1);
        end
      end else if (state == FS_HUNT && quad_ext(q)) begin
        nxt_state = last ? FS_IDLE : FS_HUNT;
      end else begin
        if (!id_ok || quad_ext(q)) begin
          seq_err = 1'b1;
        end else if (quad_more(q)) begin
          if (MAX_Q < 2 || last) seq_err = 1'b1;
          else begin
            wr_en     = 1'b1;
            nxt_state = FS_COLLECT;
            nxt_qn    = QCW'(1);
          end
        end else begin
          seq_done = 1'b1;
          seq_nq   = QCW'(1);
        end
      end
      if (seq_err) begin
        nxt_state = last ? FS_IDLE : FS_HUNT;
        nxt_qn    = '0;
      end
      if (seq_done) begin
        nxt_state = FS_IDLE;
        nxt_qn    = '0;
      end
    end
  end

  always_comb begin
    seq_words = hold_q;
    seq_words[wr_idx] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= FS_IDLE;
      qn     <= '0;
      hold_q <= '0;
    end else begin
      state <= nxt_state;
      qn    <= nxt_qn;
      if (wr_en) hold_q[wr_idx] <= q;
    end
  end

  // A quadlet either completes, fails or neither, never both.
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (rst)
    !(seq_done && seq_err));

  // While collecting, the stored length stays inside the legal window.
  p_depth_r5: assert property (@(posedge clk) disable iff (rst)
    (state == FS_COLLECT) |-> (qn >= QCW'(1) && int'(qn) < MAX_Q));

  // A batch end always leaves the framer waiting for a fresh start.
  p_last_closes_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && last) |=> (state == FS_IDLE));

  // Skipping state is only entered through an error.
  p_hunt_after_err_r9: assert property (@(posedge clk) disable iff (rst)
    (state == FS_HUNT && $past(state) != FS_HUNT) |-> $past(seq_err));

endmodule

// File: rtl/sidp_port_decoder.sv
module sidp_port_decoder
  import sidp_pkg::*;
#(
  parameter int MAX_Q = 4,
  localparam int QCW    = $clog2(MAX_Q + 1),
  localparam int NPORTS = 8 * MAX_Q - 5
) (
  input  logic [MAX_Q-1:0][QUAD_W-1:0] words,
  input  logic [QCW-1:0]               nq,
  output node_hdr_t                    hdr,
  output logic [2*NPORTS-1:0]          ports
);

  assign hdr = hdr_of(words[0]);

  for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
    localparam int W  = slot_word(gp);
    localparam int SH = slot_shift(gp);
    assign ports[2*gp +: 2] = (QCW'(W) < nq) ? words[W][SH +: 2] : 2'b00;
  end

endmodule

// File: rtl/sidp_err_counter.sv
module sidp_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  output logic             flag,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      count <= '0;
    end else begin
      flag <= hit;
      if (hit && count != '1) count <= count + CNT_W'(1);
    end
  end

  p_err_step_r10: assert property (@(posedge clk) disable iff (rst)
    (hit && count != '1) |=> (count == $past(count) + CNT_W'(1)));

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(count));

endmodule

// File: rtl/selfid_stream_parser.sv
module selfid_stream_parser
  import sidp_pkg::*;
#(
  parameter int MAX_QUADS = 4,
  parameter int ERR_W     = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [31:0]                       in_data,
  input  logic                              in_last,
  output logic                              res_valid,
  input  logic                              res_ready,
  output logic [5:0]                        res_phy_id,
  output logic                              res_link_on,
  output logic [5:0]                        res_gap,
  output logic [1:0]                        res_speed,
  output logic                              res_contender,
  output logic [2:0]                        res_power,
  output logic                              res_init_reset,
  output logic [$clog2(MAX_QUADS+1)-1:0]    res_nquad,
  output logic [2*(8*MAX_QUADS-5)-1:0]      res_ports,
  output logic                              err_flag,
  output logic [ERR_W-1:0]                  err_count
);

  localparam int QCW    = $clog2(MAX_QUADS + 1);
  localparam int NPORTS = 8 * MAX_QUADS - 5;
  localparam int PW     = 2 * NPORTS;

  logic                                 fire;
  logic                                 seq_done, seq_err;
  logic [QCW-1:0]                       seq_nq;
  logic [MAX_QUADS-1:0][QUAD_W-1:0]     seq_words;
  node_hdr_t                            dec_hdr, res_hdr;
  logic [PW-1:0]                        dec_ports;

  function automatic logic [PW-1:0] live_mask(input logic [QCW-1:0] n);
    logic [PW-1:0] m;
    for (int p = 0; p < NPORTS; p++)
      m[2*p +: 2] = (p < port_capacity(int'(n))) ? 2'b11 : 2'b00;
    return m;
  endfunction

  assign in_ready = !res_valid || res_ready;
  assign fire     = in_valid && in_ready;

  sidp_framer #(.MAX_Q(MAX_QUADS)) i_framer (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .q         (in_data),
    .last      (in_last),
    .seq_done  (seq_done),
    .seq_err   (seq_err),
    .seq_nq    (seq_nq),
    .seq_words (seq_words)
  );

  sidp_port_decoder #(.MAX_Q(MAX_QUADS)) i_decoder (
    .words (seq_words),
    .nq    (seq_nq),
    .hdr   (dec_hdr),
    .ports (dec_ports)
  );

  sidp_err_counter #(.CNT_W(ERR_W)) i_errcnt (
    .clk   (clk),
    .rst   (rst),
    .hit   (seq_err),
    .flag  (err_flag),
    .count (err_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hdr   <= '0;
      res_nquad <= '0;
      res_ports <= '0;
    end else if (seq_done) begin
      res_valid <= 1'b1;
      res_hdr   <= dec_hdr;
      res_nquad <= seq_nq;
      res_ports <= dec_ports;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assign res_phy_id     = res_hdr.phy;
  assign res_link_on    = res_hdr.link_on;
  assign res_gap        = res_hdr.gap;
  assign res_speed      = res_hdr.speed;
  assign res_contender  = res_hdr.contender;
  assign res_power      = res_hdr.power;
  assign res_init_reset = res_hdr.init_reset;

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_hdr) && $stable(res_ports) && $stable(res_nquad)));

  p_unused_zero_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((res_ports & ~live_mask(res_nquad)) == '0));

  p_len_range_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_nquad >= QCW'(1) && int'(res_nquad) <= MAX_QUADS));

  p_no_result_on_err_r4: assert property (@(posedge clk) disable iff (rst)
    (seq_err && !res_valid) |=> !res_valid);

endmodule

// File: tb/test_selfid_stream_parser.sv
module test_selfid_stream_parser;

  localparam int WD_LIMIT = 150000;

  typedef struct packed {
    logic [5:0]  phy;
    logic        link;
    logic [5:0]  gap;
    logic [1:0]  spd;
    logic        cont;
    logic [2:0]  pwr;
    logic        irst;
    logic [2:0]  nq;
    logic [53:0] ports;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [5:0]  res_phy_id;
  logic        res_link_on;
  logic [5:0]  res_gap;
  logic [1:0]  res_speed;
  logic        res_contender;
  logic [2:0]  res_power;
  logic        res_init_reset;
  logic [2:0]  res_nquad;
  logic [53:0] res_ports;
  logic        err_flag;
  logic [15:0] err_count;

  selfid_stream_parser i_selfid_stream_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .res_valid(res_valid),
    .res_ready(res_ready), .res_phy_id(res_phy_id), .res_link_on(res_link_on),
    .res_gap(res_gap), .res_speed(res_speed), .res_contender(res_contender),
    .res_power(res_power), .res_init_reset(res_init_reset),
    .res_nquad(res_nquad), .res_ports(res_ports), .err_flag(err_flag),
    .err_count(err_count)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done_run = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  rec_t        expq[$];
  int          exp_err = 0;
  int          mst = 0;          // 0 wait start, 1 collecting, 2 skipping
  int          mn  = 0;
  logic [31:0] mb [4];

  function automatic rec_t build_rec(input int n);
    rec_t r;
    r       = '0;
    r.phy   = mb[0][29:24];
    r.link  = mb[0][22];
    r.gap   = mb[0][21:16];
    r.spd   = mb[0][15:14];
    r.cont  = mb[0][11];
    r.pwr   = mb[0][10:8];
    r.irst  = mb[0][1];
    r.nq    = 3'(n);
    for (int k = 0; k < n; k++) begin
      if (k == 0) begin
        for (int j = 0; j < 3; j++) r.ports[2*j +: 2] = mb[0][7-2*j -: 2];
      end else begin
        for (int j = 0; j < 8; j++) r.ports[2*(8*k-5+j) +: 2] = mb[k][17-2*j -: 2];
      end
    end
    return r;
  endfunction

  task automatic model_step(input logic [31:0] q, input bit last, output bit e);
    bit id_ok, ext, more;
    e     = 0;
    id_ok = (q[31:30] == 2'b10);
    ext   = q[23];
    more  = q[0];
    if (mst == 2 && ext) begin
      if (last) mst = 0;
    end else begin
      if (mst != 1) begin
        if (!id_ok || ext) e = 1;
        else begin
          mb[0] = q; mn = 1;
          if (!more) begin expq.push_back(build_rec(1)); mst = 0; end
          else if (last) e = 1;
          else mst = 1;
        end
      end else begin
        if (!id_ok || !ext || q[22:20] != 3'(mn - 1)) e = 1;
        else begin
          mb[mn] = q; mn++;
          if (!more) begin expq.push_back(build_rec(mn)); mst = 0; end
          else if (mn == 4 || last) e = 1;
        end
      end
      if (e) begin
        exp_err++;
        mst = last ? 0 : 2;
      end
    end
  endtask

  // ---------------- drivers ----------------
  task automatic send_q(input logic [31:0] q, input bit last);
    bit acc, e;
    in_valid = 1; in_data = q; in_last = last;
    acc = 0; e = 0;
    while (!acc) begin
      acc = in_ready;
      @(posedge clk);
      if (acc) model_step(q, last, e);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    chk(err_flag == e, "R10 err_flag pulse", 64'(err_flag), 64'(e));
  endtask

  task automatic gap_cycles();
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic chk_errs(input string tag);
    chk(err_count == 16'(exp_err), tag, 64'(err_count), 64'(exp_err));
  endtask

  task automatic drain();
    int t = 0;
    while ((expq.size() != 0 || res_valid) && t < 400) begin
      @(negedge clk); t++;
    end
  endtask

  // mode: 0 good, 1 bad seq, 2 ext clear, 3 bad id ext, 4 bad id start,
  //       5 ext set on start, 6 overlong, 7 batch end mid-sequence
  task automatic send_seq(input int nq_i, input int mode, input bit fin_last);
    logic [31:0] w [4];
    logic [5:0]  phy;
    int nq, k, cut, nsend;
    nq  = nq_i;
    phy = 6'($urandom);
    if (mode inside {1, 2, 3, 7} && nq < 2) nq = 2;
    if (mode == 6) nq = 4;
    for (int i = 0; i < 4; i++) begin
      w[i] = $urandom;
      w[i][31:30] = 2'b10;
      w[i][29:24] = phy;
      w[i][23] = (i != 0);
      if (i != 0) w[i][22:20] = 3'(i - 1);
      w[i][0] = (i < nq - 1);
    end
    k = 1 + int'($urandom % 3);
    if (k > nq - 1) k = nq - 1;
    if (k < 1) k = 1;
    case (mode)
      1: w[k][22:20] = w[k][22:20] + 3'(1 + $urandom % 7);
      2: w[k][23] = 1'b0;
      3: w[k][31:30] = w[k][31:30] ^ 2'(1 + $urandom % 3);
      4: w[0][31:30] = w[0][31:30] ^ 2'(1 + $urandom % 3);
      5: w[0][23] = 1'b1;
      6: w[3][0] = 1'b1;
      default: ;
    endcase
    cut   = int'($urandom % (nq > 1 ? nq - 1 : 1));
    nsend = (mode == 7) ? cut + 1 : nq;
    for (int i = 0; i < nsend; i++) begin
      send_q(w[i], (mode == 7) ? (i == cut) : (i == nq - 1 && fin_last));
      gap_cycles();
    end
  endtask

  // ---------------- result monitor ----------------
  bit   prev_stall = 0;
  rec_t held;

  always @(posedge clk) begin
    #1 res_ready = (($urandom % 4) != 0);
  end

  always @(negedge clk) begin
    rec_t got, e;
    got = {res_phy_id, res_link_on, res_gap, res_speed, res_contender,
           res_power, res_init_reset, res_nquad, res_ports};
    if (!rst && !done_run) begin
      chk(in_ready == !(res_valid && !res_ready), "R11 in_ready",
          64'(in_ready), 64'(!(res_valid && !res_ready)));
      if (prev_stall)
        chk(res_valid && got == held, "R11 held result", 64'(got.ports), 64'(held.ports));
      if (res_valid && res_ready) begin
        if (expq.size() == 0) begin
          chk(0, "R3 unexpected result", 64'(got.nq), 64'(0));
        end else begin
          e = expq.pop_front();
          chk({got.phy, got.link, got.gap, got.spd, got.cont, got.pwr, got.irst} ==
              {e.phy, e.link, e.gap, e.spd, e.cont, e.pwr, e.irst}, "R2 header",
              64'({got.phy, got.link, got.gap, got.spd, got.cont, got.pwr, got.irst}),
              64'({e.phy, e.link, e.gap, e.spd, e.cont, e.pwr, e.irst}));
          chk(got.nq == e.nq, "R3 quadlet count", 64'(got.nq), 64'(e.nq));
          chk(got.ports == e.ports, "R7 port slots", 64'(got.ports), 64'(e.ports));
        end
      end
      prev_stall = res_valid && !res_ready;
      held       = got;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done_run) begin
      done_run = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h5eed_0193));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(res_valid == 0, "R1 res_valid", 64'(res_valid), 64'(0));
    chk(err_flag == 0, "R1 err_flag", 64'(err_flag), 64'(0));
    chk(err_count == 0, "R1 err_count", 64'(err_count), 64'(0));
    chk(in_ready == 1, "R1 in_ready", 64'(in_ready), 64'(1));

    // R2: fixed single-quadlet header and three port slots
    send_q({2'b10, 6'd45, 1'b0, 1'b1, 6'h2a, 2'd2, 2'b00, 1'b1, 3'd5,
            2'd3, 2'd2, 2'd1, 1'b1, 1'b0}, 1'b0);
    // R3 / R7: full four-quadlet sequence
    send_seq(4, 0, 1'b0);
    send_seq(2, 0, 1'b1);
    drain();
    chk_errs("R3 no error on good sequences");

    // R4: wrong sequence number, cleared ext bit, foreign identifier
    send_seq(3, 1, 1'b0); send_seq(1, 0, 1'b0); chk_errs("R4 bad sequence number");
    send_seq(2, 2, 1'b0); send_seq(1, 0, 1'b0); chk_errs("R4 extension bit clear");
    send_seq(4, 3, 1'b0); send_seq(2, 0, 1'b0); chk_errs("R4 foreign identifier");
    // R5: overlong sequence
    send_seq(4, 6, 1'b0); send_seq(1, 0, 1'b0); chk_errs("R5 overlong");
    // R6: bad start quadlets
    send_seq(1, 4, 1'b0); chk_errs("R6 start identifier");
    send_seq(1, 5, 1'b0); chk_errs("R6 start with ext bit");
    // R8: batch ends mid-sequence, then an extension-looking word is an error
    send_seq(3, 7, 1'b0); chk_errs("R8 cut sequence");
    send_q(32'h8080_0001, 1'b0); chk_errs("R8 fresh start after batch end");
    // R9: skipping after an error
    send_seq(3, 1, 1'b0);
    send_q(32'h8090_0000, 1'b0);
    send_q(32'h00A0_0000 | 32'h0080_0000, 1'b0);
    send_seq(3, 0, 1'b0);
    drain();
    chk_errs("R9 skipped words not counted");

    // constrained random mix
    for (int s = 0; s < 500; s++) begin
      int md;
      md = (($urandom % 10) < 6) ? 0 : 1 + int'($urandom % 7);
      send_seq(1 + int'($urandom % 4), md, ($urandom % 8) == 0);
      if (($urandom % 10) == 0) begin
        logic [31:0] j;
        j = $urandom; j[23] = 1'b1;
        send_q(j, 1'b0);
      end
    end
    drain();
    chk_errs("R10 error total");
    chk(expq.size() == 0, "R3 all results delivered", 64'(expq.size()), 64'(0));

    done_run = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_fail);
    $finish;
  end

endmodule